// File: doc/BRIEF.md
# SPI Master Serial-Clock Rate Generator

This block turns the bus clock into the serial clock timing for an SPI master. Two counting stages are chained. A linear prescaler divides the bus clock by 1 to 8. Its output paces a second stage that divides by a power of two from 2 to 512. The serial clock period is therefore the bus clock period multiplied by the product of the two divisors.

The transfer engine raises `run` for the duration of a transfer. While `run` is high, the block pulses `sck_tick` for one cycle at every point where the serial clock should change level, and `sck` toggles on the edge after each pulse. When `run` is low, both counters are held at zero and `sck` rests low. Each rising edge of `run` therefore begins a fresh, full-length half-period. The two select fields are sampled only while `run` is low, so a transfer always runs at one fixed rate.

Top module: `sck_rate_gen`

## Requirements
- R1: After a synchronous reset, `sck_tick` is 0 and `sck` is 0.
- R2: While `run` is low, `sck_tick` is 0. On the first clock edge that samples `run` low, `sck` returns to 0 and then stays there.
- R3: Prescaler code n on `pre_sel` (3 bits, unsigned) selects a prescale factor of n+1. Code 0 passes the bus clock through unchanged and code 7 divides by 8.
- R4: Divider code k on `div_sel` (4 bits, unsigned, k from 0 to 8) selects a divisor of 2^(k+1). Consecutive `sck_tick` pulses are spaced (n+1)*2^k bus cycles apart.
- R5: Reserved divider codes 9 through 15 behave exactly like code 8, which gives a divisor of 512.
- R6: Consecutive ticks within a transfer are equally spaced. As a result, `sck` is high for exactly as many cycles as it is low.
- R7: Counting starts from zero at each rise of `run`. The first tick appears after (n+1)*2^k - 1 clock edges with `run` high, so the first `sck` half-period has full length.
- R8: A select value takes effect only if it is present at a clock edge where `run` is low. A change made while `run` is high does not alter the current transfer's rate, and it applies from the next start.
- R9: While `run` is high, `sck` inverts on the clock edge after each `sck_tick` pulse and holds its value otherwise.
- R10: Dropping `run` in the middle of a half-period abandons that half-period. The next start produces a full first half-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Transfer active, from the transfer engine |
| pre_sel | input | 3 | Prescaler code |
| div_sel | input | 4 | Power-of-two divider code |
| sck_tick | output | 1 | One-cycle pulse at each serial clock edge point |
| sck | output | 1 | Serial clock level, idle low |

## Verification
The hardest case to reach from the ports is a select change that lands during a transfer. The change must not alter the running rate, and it must then take effect at the very next start. The stimulus starts a transfer, rewrites both fields in the same cycle that `run` rises, and measures the tick spacing against the old setting. It then stops the transfer, restarts it, and measures again against the new setting. The largest setting, which combines a reserved divider code with the top prescaler code, is also measured, so that the full 2048-cycle half-period is covered.

// File: rtl/sck_rate_pkg.sv
package sck_rate_pkg;
  localparam int unsigned PRE_W_DEF     = 3;
  localparam int unsigned SEL_W_DEF     = 4;
  localparam int unsigned NUM_CODES_DEF = 9;

  // prescale factor for a prescaler code: linear, code + 1
  function automatic int unsigned pre_divisor(input int unsigned code);
    return code + 1;
  endfunction

  // half of the power-of-two divisor; codes past the last legal one clamp to it
  function automatic int unsigned half_divisor(input int unsigned code,
                                               input int unsigned ncodes);
    int unsigned c;
    c = (code >= ncodes) ? ncodes - 1 : code;
    return 32'd1 << c;
  endfunction
endpackage

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] last,
  output logic             pre_tick,
  output logic [PRE_W-1:0] count
);
  assign pre_tick = run && (count == last);

  always_ff @(posedge clk) begin
    if (rst || !run)   count <= '0;
    else if (pre_tick) count <= '0;
    else               count <= count + 1'b1;
  end
endmodule

// File: rtl/sck_pow2_div.sv
module sck_pow2_div #(
  parameter int unsigned DC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            pre_tick,
  input  logic [DC_W-1:0] half_last,
  output logic            half_tick,
  output logic [DC_W-1:0] count
);
  assign half_tick = pre_tick && (count == half_last);

  always_ff @(posedge clk) begin
    if (rst || !run)    count <= '0;
    else if (half_tick) count <= '0;
    else if (pre_tick)  count <= count + 1'b1;
  end
endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen
  import sck_rate_pkg::*;
#(
  parameter int unsigned PRE_W     = PRE_W_DEF,
  parameter int unsigned SEL_W     = SEL_W_DEF,
  parameter int unsigned NUM_CODES = NUM_CODES_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [SEL_W-1:0] div_sel,
  output logic             sck_tick,
  output logic             sck
);
  localparam int unsigned DC_W = NUM_CODES - 1;

  logic [PRE_W-1:0] cfg_pre;
  logic [SEL_W-1:0] cfg_div;
  logic [PRE_W-1:0] pre_last;
  logic [DC_W-1:0]  half_last;
  logic             pre_tick;
  logic [PRE_W-1:0] pre_cnt;
  logic [DC_W-1:0]  div_cnt;

  // selects are captured only between transfers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_pre <= '0;
      cfg_div <= '0;
    end else if (!run) begin
      cfg_pre <= pre_sel;
      cfg_div <= div_sel;
    end
  end

  assign pre_last  = PRE_W'(pre_divisor(32'(cfg_pre)) - 1);
  assign half_last = DC_W'(half_divisor(32'(cfg_div), NUM_CODES) - 1);

  sck_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .last     (pre_last),
    .pre_tick (pre_tick),
    .count    (pre_cnt)
  );

  sck_pow2_div #(.DC_W(DC_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .pre_tick  (pre_tick),
    .half_last (half_last),
    .half_tick (sck_tick),
    .count     (div_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || !run)   sck <= 1'b0;
    else if (sck_tick) sck <= ~sck;
  end
endmodule

// File: rtl/sck_rate_gen_chk.sv
module sck_rate_gen_chk #(
  parameter int unsigned PRE_W = 3,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned DC_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             sck_tick,
  input logic             sck,
  input logic             pre_tick,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [DC_W-1:0]  div_cnt,
  input logic [DC_W-1:0]  half_last,
  input logic [PRE_W-1:0] cfg_pre,
  input logic [SEL_W-1:0] cfg_div
);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sck);
  p_idle_notick_r2: assert property (@(posedge clk) disable iff (rst)
    !run |-> !sck_tick);
  p_pre_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    pre_tick |=> (pre_cnt == '0));
  p_tick_on_pre_r4: assert property (@(posedge clk) disable iff (rst)
    sck_tick |-> pre_tick);
  p_div_range_r6: assert property (@(posedge clk) disable iff (rst)
    div_cnt <= half_last);
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (pre_cnt == '0) && (div_cnt == '0));
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(cfg_pre) && $stable(cfg_div));
  p_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    (run && sck_tick) |=> (sck != $past(sck)));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !sck_tick) |=> $stable(sck));
endmodule

bind sck_rate_gen sck_rate_gen_chk #(
  .PRE_W(PRE_W), .SEL_W(SEL_W), .DC_W(DC_W)
) u_chk (
  .clk(clk), .rst(rst), .run(run), .sck_tick(sck_tick), .sck(sck),
  .pre_tick(pre_tick), .pre_cnt(pre_cnt), .div_cnt(div_cnt),
  .half_last(half_last), .cfg_pre(cfg_pre), .cfg_div(cfg_div)
);

// File: tb/sck_rate_gen_tb.sv
module sck_rate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic [2:0] pre_sel = '0;
  logic [3:0] div_sel = '0;
  logic       sck_tick;
  logic       sck;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sck_rate_gen u_dut (
    .clk(clk), .rst(rst), .run(run), .pre_sel(pre_sel), .div_sel(div_sel),
    .sck_tick(sck_tick), .sck(sck)
  );

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // half-period in bus cycles, restated from R3/R4/R5
  function automatic int exp_half(input int p, input int d);
    int k;
    k = (d > 8) ? 8 : d;
    return (p + 1) * (2 ** k);
  endfunction

  // count edges until sck_tick is seen; sampled 1 time unit after a negedge
  task automatic wait_tick(output int n);
    n = 0;
    #1;
    while (!sck_tick && n < LIMIT) begin
      @(negedge clk); #1;
      n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(sck_tick, 0, "R1 tick after reset");
    check(sck, 0, "R1 sck after reset");
  endtask

  // start a transfer and measure first half-period plus three further ones
  task automatic t_rate(input int p, input int d, input bit chg, input string tag);
    int hp, n;
    bit lvl;
    hp = exp_half(p, d);
    @(negedge clk);
    run = 1'b0; pre_sel = 3'(p); div_sel = 4'(d);
    @(negedge clk);
    @(negedge clk);
    run = 1'b1;
    if (chg) begin  // R8: rewrite both fields while running
      pre_sel = 3'(7 - p); div_sel = 4'(15 - d);
    end
    wait_tick(n);
    check(n, hp - 1, {tag, " R7 first half-period edges"});
    lvl = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      lvl = ~lvl;
      check(sck, lvl, {tag, " R9 sck after tick"});
      n = 1;
      while (!sck_tick && n < LIMIT) begin
        @(negedge clk); #1;
        n++;
      end
      check(n, hp, {tag, " R6 tick spacing"});
    end
    @(negedge clk);
    run = 1'b0;
    #1;
    check(sck_tick, 0, {tag, " R2 no tick when idle"});
    @(negedge clk); #1;
    check(sck, 0, {tag, " R2 sck idle"});
  endtask

  // R10: stop in mid half-period, then restart full length
  task automatic t_abort();
    int n;
    @(negedge clk);
    run = 1'b0; pre_sel = 3'd1; div_sel = 4'd3;  // half = 16
    @(negedge clk);
    @(negedge clk);
    run = 1'b1;
    wait_tick(n);
    repeat (6) @(negedge clk);
    #1;
    check(sck, 1, "R10 sck high mid half-period");
    run = 1'b0;
    @(negedge clk); #1;
    check(sck, 0, "R10 sck dropped on abort");
    repeat (3) begin
      @(negedge clk); #1;
      check(sck_tick, 0, "R2 tick stays low while idle");
    end
    run = 1'b1;
    wait_tick(n);
    check(n, 15, "R10 full first half-period after restart");
    @(negedge clk);
    run = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rate(0, 0, 1'b0, "R3 R4 p0 d0");
    t_rate(3, 0, 1'b0, "R3 p3");
    t_rate(7, 0, 1'b0, "R3 p7");
    t_rate(0, 3, 1'b0, "R4 d3");
    t_rate(2, 5, 1'b0, "R4 p2 d5");
    t_rate(1, 8, 1'b0, "R4 p1 d8");
    t_rate(7, 12, 1'b0, "R5 p7 d12");
    t_rate(0, 15, 1'b0, "R5 p0 d15");
    t_rate(0, 1, 1'b1, "R8 change held off");
    // fields now hold the values written mid-transfer: 7 and 14
    t_rate(7, 14, 1'b0, "R8 change applied at restart");
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule